// File: doc/BRIEF.md
# Single-Buffered SPI Master

This block is an SPI master that a processor drives through a small register bus with three registers: control, status and data. Writing the data register puts the byte straight into the shift register and starts an eight-bit exchange at once. There is no transmit holding stage, so the byte being shifted is the byte that was written. The byte shifted in on the receive line is copied into a separate read buffer when the exchange ends. Software can therefore start the next exchange first and collect the previous byte while the new one shifts.

A done flag in the status register reports that an exchange has finished. A write to the data register while an exchange is still running is refused. It is recorded as a write collision and does not disturb the exchange in progress. With the clock-double option set, the serial clock runs at half the system clock and a byte takes 16 system cycles. Without it, the serial clock runs at a quarter of the system clock and a byte takes 32 cycles.

Register map, with `reg_addr` as the select: 0 is control, 1 is status, 2 is data, and 3 reads as zero. Reads are combinational on `reg_rdata`. Read side effects take place at the clock edge where `reg_rd` is high.

Top module: `spi_sb_master`

## Requirements
- R1: After reset the control and status registers read 0x00, the read buffer reads 0x00, and `sck` is low.
- R2: The link runs in SPI mode 0 with the most significant bit first. `sck` idles low, `miso` is sampled on each rising `sck` edge, and `mosi` changes only on falling `sck` edges. Each exchange gives exactly 8 rising edges.
- R3: Writing address 2 while idle and enabled starts an exchange of that byte at the same clock edge. With control bit 2 set, status bit 7 (done) is still 0 fifteen cycles after the write edge and reads 1 sixteen cycles after it.
- R4: A data write arriving while an exchange runs sets status bit 6 (collision). That byte is never sent and the running exchange completes unchanged. A write made 17 cycles after an accepted write is accepted.
- R5: At the end of an exchange the received byte moves to the read buffer. Reads of address 2 return that buffer, including while a later exchange is shifting. Data writes never change what address 2 reads back.
- R6: Status bits 7 and 6 clear only when a status read made while either bit was set is followed by an access to address 2. A data access without that earlier status read leaves them set.
- R7: Control bit 0 (enable) and bit 1 (master) must both be 1 for a data write to start an exchange. Otherwise the write produces no `sck` edge and no collision.
- R8: With control bit 2 clear, the serial clock runs at one quarter of the system clock. Done is 0 thirty-one cycles after the write edge and 1 thirty-two cycles after it.
- R9: Control bits 2:0 read back as written, and bits 7:3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case is a data write that lands on the exact edge where the exchange finishes. The block is then still busy, so the write must count as a collision, while the next cycle must accept a new byte. The stimulus starts an exchange and steps exactly fifteen negative edges. It then writes on the sixteenth edge and again on the seventeenth. The bench checks that the collision and done flags rise together, that the slave model receives only the first byte and the third, and that reading the buffer during the third exchange still returns the byte from the first.

// File: rtl/spi_sb_pkg.sv
package spi_sb_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTL_EN  = 0;
  localparam int CTL_MST = 1;
  localparam int CTL_DBL = 2;

  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;

  // system cycles per serial-clock half period
  function automatic int unsigned half_len(input logic dbl);
    return dbl ? 1 : 2;
  endfunction

  // system cycles from accepting write to completion edge
  function automatic int unsigned xfer_cycles(input logic dbl, input int unsigned bits);
    return 2 * bits * half_len(dbl);
  endfunction

endpackage

// File: rtl/spi_sb_shifter.sv
module spi_sb_shifter
  import spi_sb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_dbl,
  input  logic [DW-1:0] tx_byte,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          xfer_end,
  output logic [DW-1:0] rx_byte
);
  localparam int PW = $clog2(2 * DW);
  localparam logic [PW-1:0] LAST_PH = PW'(2 * DW - 1);

  logic [PW-1:0] ph_q;
  logic          div_q;
  logic          dbl_q;
  logic          busy_q;
  logic          sck_q;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic          tick;

  assign tick     = busy_q && (dbl_q || div_q);
  assign xfer_end = tick && (ph_q == LAST_PH);
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign mosi     = tx_sh[DW-1];
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      div_q  <= 1'b0;
      dbl_q  <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start) begin
      ph_q   <= '0;
      div_q  <= 1'b0;
      dbl_q  <= start_dbl;
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      tx_sh  <= tx_byte;
    end else if (busy_q) begin
      div_q <= ~div_q;
      if (tick) begin
        ph_q <= ph_q + 1'b1;
        if (!ph_q[0]) begin
          sck_q <= 1'b1;
          rx_sh <= {rx_sh[DW-2:0], miso};
        end else begin
          sck_q <= 1'b0;
          if (ph_q == LAST_PH) busy_q <= 1'b0;
          else                 tx_sh  <= tx_sh << 1;
        end
      end
    end
  end

  // checker counter: cycles since the accepting edge
  logic [15:0] chk_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_cyc <= '0;
    else if (start)  chk_cyc <= '0;
    else if (busy_q) chk_cyc <= chk_cyc + 1'b1;
  end

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  a_r2_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && $rose(sck_q)) |-> $stable(mosi));

  a_r3_xfer_length: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (32'(chk_cyc) == xfer_cycles(dbl_q, DW) - 1));

endmodule

// File: rtl/spi_sb_regs.sv
module spi_sb_regs
  import spi_sb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          xfer_end,
  input  logic [DW-1:0] rx_byte,
  output logic          start,
  output logic          start_dbl,
  output logic [DW-1:0] tx_byte
);
  logic          en_q, mst_q, dbl_q;
  logic          done_q, coll_q, armed_q;
  logic [DW-1:0] rx_buf;

  logic wr_data, data_acc, rd_stat, coll_ev, clr_ev;

  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
  assign start    = wr_data && !busy && en_q && mst_q;
  assign coll_ev  = wr_data && busy;
  assign clr_ev   = armed_q && data_acc;
  assign start_dbl = dbl_q;
  assign tx_byte  = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; dbl_q <= 1'b0;
    end else if (reg_wr && (reg_addr == ADDR_CTRL)) begin
      en_q  <= reg_wdata[CTL_EN];
      mst_q <= reg_wdata[CTL_MST];
      dbl_q <= reg_wdata[CTL_DBL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (xfer_end)    done_q <= 1'b1;
      else if (clr_ev) done_q <= 1'b0;
      if (coll_ev)     coll_q <= 1'b1;
      else if (clr_ev) coll_q <= 1'b0;
      if (clr_ev)                           armed_q <= 1'b0;
      else if (rd_stat && (done_q || coll_q)) armed_q <= 1'b1;
      if (xfer_end) rx_buf <= rx_byte;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTL_EN]  = en_q;
        reg_rdata[CTL_MST] = mst_q;
        reg_rdata[CTL_DBL] = dbl_q;
      end
      ADDR_STAT: begin
        reg_rdata[ST_DONE] = done_q;
        reg_rdata[ST_COLL] = coll_q;
      end
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end

  a_r4_collision_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DATA && busy) |=> coll_q);

  a_r3_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_q);

  a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_q && mst_q));

  a_r6_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !armed_q) |=> done_q);

endmodule

// File: rtl/spi_sb_master.sv
module spi_sb_master
  import spi_sb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  logic          busy, xfer_end, start, start_dbl;
  logic [DW-1:0] rx_byte, tx_byte;

  spi_sb_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .xfer_end(xfer_end), .rx_byte(rx_byte),
    .start(start), .start_dbl(start_dbl), .tx_byte(tx_byte)
  );

  spi_sb_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_dbl(start_dbl), .tx_byte(tx_byte),
    .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
    .xfer_end(xfer_end), .rx_byte(rx_byte)
  );

  a_r4_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_end) |=> busy);

endmodule

// File: tb/spi_sb_master_tb.sv
module spi_sb_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck, mosi, miso;

  int n_cmp = 0, n_bad = 0, rises = 0, sl_bits = 0;
  bit done = 0;
  logic [7:0] sl_tx = 8'h00, sl_rx = 8'h00;
  logic [7:0] exp_q[$];
  logic [7:0] v;
  int r0;

  always #5 clk = ~clk;

  spi_sb_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  assign miso = sl_tx[7];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor (R2: sample on rise, MSB first)
  always @(posedge sck) begin
    rises++;
    sl_rx = {sl_rx[6:0], mosi};
    sl_bits++;
    if (sl_bits == 8) begin
      sl_bits = 0;
      if (exp_q.size() == 0) chk("R4 unexpected byte on mosi", sl_rx, 8'hxx);
      else chk("R2 mosi byte", sl_rx, exp_q.pop_front());
    end
  end
  always @(negedge sck) sl_tx = sl_tx << 1;

  // all tasks are entered and left at a negative clock edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic send(input logic [7:0] d);
    exp_q.push_back(d);
    wr(2'd2, d);
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    reg_addr = a; reg_rd = 1'b1; #1 q = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask
  task automatic peek(input logic [1:0] a, output logic [7:0] q);
    reg_addr = a; #1 q = reg_rdata;
  endtask
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
    peek(2'd1, v); chk("R1 status", v, 8'h00);
    peek(2'd2, v); chk("R1 rx buffer", v, 8'h00);
    chk("R1 sck low", {7'd0, sck}, 8'h00);

    // R7 enable without master: write ignored
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h55);
    step(40);
    chk("R7 no sck edges", 8'(rises), 8'd0);
    peek(2'd1, v); chk("R7 no flags", v, 8'h00);

    // R9 control readback
    wr(2'd0, 8'hFF);
    peek(2'd0, v); chk("R9 ctrl readback", v, 8'h07);

    // R3 half-clock timing
    sl_tx = 8'h3C; r0 = rises;
    send(8'hA5);
    step(15);
    peek(2'd1, v); chk("R3 done not yet at 15", v, 8'h00);
    step(1);
    peek(2'd1, v); chk("R3 done at 16", v, 8'h80);
    chk("R2 eight rises", 8'(rises - r0), 8'd8);
    chk("R2 sck idle low", {7'd0, sck}, 8'h00);

    // R5 read buffer, R6 data access alone does not clear
    rd(2'd2, v); chk("R5 rx byte", v, 8'h3C);
    peek(2'd1, v); chk("R6 still set without status read", v, 8'h80);
    rd(2'd1, v);
    rd(2'd2, v);
    peek(2'd1, v); chk("R6 cleared", v, 8'h00);

    // R4 collision on the completing edge, then accept at 17
    sl_tx = 8'h81;
    send(8'h5A);
    step(15);
    wr(2'd2, 8'hFF);
    peek(2'd1, v); chk("R4 done and collision", v, 8'hC0);
    sl_tx = 8'h7E;
    send(8'h96);
    rd(2'd2, v); chk("R5 previous byte during transfer", v, 8'h81);
    step(15);
    peek(2'd1, v); chk("R4 second transfer done", v, 8'hC0);
    rd(2'd2, v); chk("R5 new rx byte", v, 8'h7E);
    rd(2'd1, v);
    rd(2'd2, v);
    peek(2'd1, v); chk("R6 both flags cleared", v, 8'h00);

    // R8 quarter clock
    wr(2'd0, 8'h03);
    sl_tx = 8'hC3; r0 = rises;
    send(8'h12);
    step(31);
    peek(2'd1, v); chk("R8 done not yet at 31", v, 8'h00);
    step(1);
    peek(2'd1, v); chk("R8 done at 32", v, 8'h80);
    chk("R8 eight rises", 8'(rises - r0), 8'd8);
    rd(2'd2, v); chk("R8 rx byte", v, 8'hC3);

    step(4);
    chk("R4 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1;
    summary();
  end
endmodule